// File: doc/BRIEF.md
# Serial PCM Master Clock Generator

This block runs from a fixed reference clock (20.48 MHz in the target system). It produces the master bit clock of a time-division serial data bus, a transmit frame-sync strobe, a matching receive frame-sync strobe and a timeslot-enable strobe. Three bit-clock rates are available: 512 kHz, 2.048 MHz and 2.56 MHz. At every rate a frame lasts 2560 reference cycles, which is 125 us. Counting the reference cycles that each bit-clock phase spans gives a bit period of 40, 10 or 8 cycles. Counting bit-clock pulses gives a frame of 64, 256 or 320 pulses.

To track a clock recovered from a line, a controller pulses an adjustment request and gives a direction with it. The block latches the request. On each of the two frames that follow, it lengthens (retard) or shortens (advance) the high phase of one fixed pulse of the frame by exactly one reference cycle. That is pulse 249 at the two faster rates and pulse 59 at 512 kHz. The low phase of the bit clock is never altered. All control inputs are plain level or pulse pins, and the block has no data stream, so it has no handshake.

Top module: `pcm_master_clkgen`

## Requirements
- R1: While rst_n is low, bclk is high, fs_tx and fs_rx are low, and the active rate is 2.048 MHz.
- R2: Each unadjusted bit-clock pulse is high for H reference cycles and then low for H cycles. H is 20 at 512 kHz, 5 at 2.048 MHz and 4 at 2.56 MHz.
- R3: A frame is 2560 reference cycles long and holds 64, 256 or 320 bit-clock rising edges, depending on the rate. fs_tx is high for exactly the last bit period of each frame (2H cycles), and fs_rx equals fs_tx in every cycle.
- R4: Pulse numbering starts at 0 with the bit-clock pulse that begins in the cycle after fs_tx falls.
- R5: An adjustment with adj_dir=1 (retard) makes the high phase of the target pulse H+1 cycles. An adjustment with adj_dir=0 (advance) makes it H-1 cycles. The low phase of that pulse stays H cycles. The target pulse is number 249 at 2.048 MHz and 2.56 MHz, and number 59 at 512 kHz.
- R6: A request sampled on adj_req is applied on the first two frames that begin after it. The frame in which it arrives is not adjusted, and neither is the third frame.
- R7: A request that arrives while an earlier adjustment is still pending is ignored. It neither changes the direction nor extends the adjustment.
- R8: rate_sel is sampled only at frame boundaries, and the new rate starts with pulse 0 of the next frame. The encoding is 00 for 512 kHz, 01 for 2.048 MHz, 10 for 2.56 MHz, and 11, which selects 2.048 MHz.
- R9: A rate change taken at a frame boundary cancels any pending adjustment.
- R10: ts_en is high for whole bit periods, selected by ch_en. ch_en bit 0 selects pulses 0-7 (B1), bit 1 selects pulses 8-15 (B2) and bit 2 selects pulses 16-17 (D).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 2 | Requested bit-clock rate, taken at frame boundaries |
| adj_req | input | 1 | One-cycle phase adjustment request |
| adj_dir | input | 1 | Adjustment direction: 1 retard (longer high), 0 advance |
| ch_en | input | 3 | Channel mask for the timeslot-enable strobe: D, B2, B1 |
| bclk | output | 1 | Master bit clock |
| fs_tx | output | 1 | Transmit frame sync |
| fs_rx | output | 1 | Receive frame sync |
| ts_en | output | 1 | Timeslot enable |

## Verification
A wrong reference-cycle count inside a bit shows up within one bit period as a high or low phase of the wrong length. A wrong pulse count first shows up at the next frame boundary: frame sync lands at the wrong place and the frame is no longer 2560 cycles long. Faults in the adjustment state stay hidden until pulse 249 or 59 of the following two or three frames. Each of those frames is measured, so a missing, extra, reversed or uncancelled adjustment is exposed no more than three frames after the request.

// File: rtl/pcm_clk_pkg.sv
package pcm_clk_pkg;
  typedef enum logic [1:0] {
    RATE_SLOW = 2'd0,
    RATE_MID  = 2'd1,
    RATE_FAST = 2'd2
  } rate_t;

  function automatic rate_t decode_rate(input logic [1:0] code);
    case (code)
      2'd0:    decode_rate = RATE_SLOW;
      2'd2:    decode_rate = RATE_FAST;
      default: decode_rate = RATE_MID;
    endcase
  endfunction
endpackage

// File: rtl/pcm_bit_timer.sv
module pcm_bit_timer #(
  parameter int PH_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PH_W-1:0] half,
  input  logic            stretch,
  input  logic            shrink,
  output logic            bclk,
  output logic            bit_end
);
  logic [PH_W-1:0] ph;
  logic [PH_W-1:0] hi_len;
  logic [PH_W-1:0] plen;

  assign hi_len  = half + PH_W'(stretch) - PH_W'(shrink);
  assign plen    = hi_len + half;
  assign bit_end = (ph == plen - PH_W'(1));
  assign bclk    = (ph < hi_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ph <= '0;
    else if (bit_end) ph <= '0;
    else              ph <= ph + PH_W'(1);
  end

  // R2
  ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph < plen);

  // R5
  low_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bclk && !bit_end) |=> !bclk);
endmodule

// File: rtl/pcm_frame_ctr.sv
module pcm_frame_ctr #(
  parameter int PC_W   = 9,
  parameter int B_BITS = 8,
  parameter int D_BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bit_end,
  input  logic [PC_W-1:0] npulse,
  input  logic [2:0]      ch_en,
  output logic [PC_W-1:0] pc,
  output logic            frame_end,
  output logic            fsync,
  output logic            ts_en
);
  localparam int B2_END = 2 * B_BITS;
  localparam int D_END  = B2_END + D_BITS;

  logic in_b1, in_b2, in_d;

  assign fsync     = (pc == npulse - PC_W'(1));
  assign frame_end = bit_end && fsync;

  assign in_b1 = (pc < PC_W'(B_BITS));
  assign in_b2 = (pc >= PC_W'(B_BITS)) && (pc < PC_W'(B2_END));
  assign in_d  = (pc >= PC_W'(B2_END)) && (pc < PC_W'(D_END));
  assign ts_en = (ch_en[0] && in_b1) || (ch_en[1] && in_b2) || (ch_en[2] && in_d);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         pc <= '0;
    else if (frame_end) pc <= '0;
    else if (bit_end)   pc <= pc + PC_W'(1);
  end

  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (pc == '0));

  // R4
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_end |=> $stable(pc));
endmodule

// File: rtl/pcm_phase_steer.sv
module pcm_phase_steer (
  input  logic clk,
  input  logic rst_n,
  input  logic adj_req,
  input  logic adj_dir,
  input  logic frame_end,
  input  logic bit_end,
  input  logic at_adj,
  input  logic cancel,
  output logic stretch,
  output logic shrink
);
  logic [1:0] left;
  logic       go;
  logic       dir_q;
  logic       take;

  assign take    = adj_req && (left == 2'd0);
  assign stretch = go && at_adj && dir_q;
  assign shrink  = go && at_adj && !dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left  <= 2'd0;
      go    <= 1'b0;
      dir_q <= 1'b0;
    end else if (frame_end) begin
      if (cancel) begin
        left <= 2'd0;
        go   <= 1'b0;
      end else begin
        go <= (left != 2'd0);
        if (take) begin
          left  <= 2'd2;
          dir_q <= adj_dir;
        end
      end
    end else if (go && at_adj && bit_end) begin
      left <= left - 2'd1;
      if (left == 2'd1) go <= 1'b0;
    end else if (take) begin
      left  <= 2'd2;
      dir_q <= adj_dir;
    end
  end

  // R6
  left_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (left <= 2'd2) && (!go || left != 2'd0));

  // R7
  ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_req && left != 2'd0) |=> $stable(dir_q));

  // R9
  cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && cancel) |=> (left == 2'd0 && !go));
endmodule

// File: rtl/pcm_master_clkgen.sv
module pcm_master_clkgen
  import pcm_clk_pkg::*;
#(
  parameter int HALF_SLOW   = 20,
  parameter int HALF_MID    = 5,
  parameter int HALF_FAST   = 4,
  parameter int PULSES_SLOW = 64,
  parameter int PULSES_MID  = 256,
  parameter int PULSES_FAST = 320,
  parameter int ADJ_SLOW    = 59,
  parameter int ADJ_HI      = 249,
  parameter int B_BITS      = 8,
  parameter int D_BITS      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] rate_sel,
  input  logic       adj_req,
  input  logic       adj_dir,
  input  logic [2:0] ch_en,
  output logic       bclk,
  output logic       fs_tx,
  output logic       fs_rx,
  output logic       ts_en
);
  localparam int MAX_HALF = (HALF_SLOW > HALF_MID) ?
    ((HALF_SLOW > HALF_FAST) ? HALF_SLOW : HALF_FAST) :
    ((HALF_MID > HALF_FAST) ? HALF_MID : HALF_FAST);
  localparam int MAX_PULSES = (PULSES_SLOW > PULSES_MID) ?
    ((PULSES_SLOW > PULSES_FAST) ? PULSES_SLOW : PULSES_FAST) :
    ((PULSES_MID > PULSES_FAST) ? PULSES_MID : PULSES_FAST);
  localparam int PH_W = $clog2(2 * MAX_HALF + 2);
  localparam int PC_W = $clog2(MAX_PULSES + 1);

  rate_t           rate_q, rate_new;
  logic [PH_W-1:0] half;
  logic [PC_W-1:0] npulse, adj_idx, pc;
  logic            bit_end, frame_end, fsync, stretch, shrink, cancel, at_adj;

  assign rate_new = decode_rate(rate_sel);
  assign cancel   = frame_end && (rate_new != rate_q);
  assign at_adj   = (pc == adj_idx);

  always_comb begin
    case (rate_q)
      RATE_SLOW: begin
        half = PH_W'(HALF_SLOW); npulse = PC_W'(PULSES_SLOW); adj_idx = PC_W'(ADJ_SLOW);
      end
      RATE_FAST: begin
        half = PH_W'(HALF_FAST); npulse = PC_W'(PULSES_FAST); adj_idx = PC_W'(ADJ_HI);
      end
      default: begin
        half = PH_W'(HALF_MID);  npulse = PC_W'(PULSES_MID);  adj_idx = PC_W'(ADJ_HI);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rate_q <= RATE_MID;
    else if (frame_end) rate_q <= rate_new;
  end

  pcm_bit_timer #(.PH_W(PH_W)) u_bit (
    .clk(clk), .rst_n(rst_n), .half(half), .stretch(stretch), .shrink(shrink),
    .bclk(bclk), .bit_end(bit_end)
  );

  pcm_frame_ctr #(.PC_W(PC_W), .B_BITS(B_BITS), .D_BITS(D_BITS)) u_frame (
    .clk(clk), .rst_n(rst_n), .bit_end(bit_end), .npulse(npulse), .ch_en(ch_en),
    .pc(pc), .frame_end(frame_end), .fsync(fsync), .ts_en(ts_en)
  );

  pcm_phase_steer u_steer (
    .clk(clk), .rst_n(rst_n), .adj_req(adj_req), .adj_dir(adj_dir),
    .frame_end(frame_end), .bit_end(bit_end), .at_adj(at_adj), .cancel(cancel),
    .stretch(stretch), .shrink(shrink)
  );

  assign fs_tx = fsync;
  assign fs_rx = fsync;

  // R8
  rate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(rate_q));
endmodule

// File: tb/tb_pcm_master_clkgen.sv
module tb_pcm_master_clkgen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] rate_sel = 2'd1;
  logic       adj_req = 1'b0;
  logic       adj_dir = 1'b0;
  logic [2:0] ch_en = 3'b000;
  logic       bclk, fs_tx, fs_rx, ts_en;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pcm_master_clkgen dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .adj_req(adj_req),
    .adj_dir(adj_dir), .ch_en(ch_en), .bclk(bclk), .fs_tx(fs_tx),
    .fs_rx(fs_rx), .ts_en(ts_en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_frame_start();
    int n = 0;
    bit pf;
    do begin
      pf = fs_tx;
      @(negedge clk);
      n++;
    end while (!(pf && !fs_tx) && n < 4000);
  endtask

  task automatic measure_pulse(output int hi, output int lo);
    hi = 0; lo = 0;
    while (bclk && hi < 100) begin hi++; @(negedge clk); end
    while (!bclk && lo < 100) begin lo++; @(negedge clk); end
  endtask

  task automatic skip_pulses(input int n);
    int h, l;
    for (int i = 0; i < n; i++) measure_pulse(h, l);
  endtask

  task automatic fire_req(input bit dir);
    adj_dir = dir;
    adj_req = 1'b1;
    fork
      begin @(negedge clk); adj_req = 1'b0; end
    join_none
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(bclk == 1'b1, "R1 bclk in reset", bclk, 1);
    check(fs_tx == 1'b0 && fs_rx == 1'b0, "R1 frame sync in reset", fs_tx, 0);
    @(negedge clk); rst_n = 1'b1;
    begin
      int h, l;
      measure_pulse(h, l);
      check(h == 5 && l == 5, "R1 default rate high", h, 5);
    end
  endtask

  task automatic t_rate(input logic [1:0] code, input int h_new, input int np, input int h_old);
    int h, l, cyc, fsc, rises, mism;
    bit pb, pf;
    wait_frame_start();
    rate_sel = code;
    measure_pulse(h, l);
    check(h == h_old, "R8 rate held until boundary", h, h_old);
    wait_frame_start();
    cyc = 0; fsc = 0; rises = 0; mism = 0;
    do begin
      pb = bclk; pf = fs_tx;
      @(negedge clk);
      cyc++;
      if (fs_tx) fsc++;
      if (bclk && !pb) rises++;
      if (fs_rx != fs_tx) mism++;
    end while (!(pf && !fs_tx) && cyc < 4000);
    check(cyc == 2560, "R3 frame length", cyc, 2560);
    check(rises == np, "R3 pulses per frame", rises, np);
    check(fsc == 2 * h_new, "R3 frame sync width", fsc, 2 * h_new);
    check(mism == 0, "R3 fs_rx equals fs_tx", mism, 0);
    measure_pulse(h, l);
    check(h == h_new, "R2 high phase", h, h_new);
    check(l == h_new, "R2 low phase", l, h_new);
    check(bclk == 1'b1, "R4 pulse 1 starts high", bclk, 1);
  endtask

  task automatic t_adjust(input logic [1:0] code, input int hh, input int adj, input bit dir);
    int h, l, exp;
    rate_sel = code;
    wait_frame_start();
    wait_frame_start();
    fire_req(dir);
    skip_pulses(adj);
    measure_pulse(h, l);
    check(h == hh, "R6 request frame untouched", h, hh);
    for (int f = 1; f <= 3; f++) begin
      wait_frame_start();
      skip_pulses(adj);
      measure_pulse(h, l);
      exp = (f <= 2) ? (dir ? hh + 1 : hh - 1) : hh;
      check(h == exp, (f <= 2) ? "R5 adjusted high phase" : "R6 third frame nominal", h, exp);
      check(l == hh, "R5 low phase unchanged", l, hh);
    end
  endtask

  task automatic t_ignore();
    int h, l;
    wait_frame_start();
    fire_req(1'b1);
    wait_frame_start();
    fire_req(1'b0);
    skip_pulses(249);
    measure_pulse(h, l);
    check(h == 6, "R7 first frame keeps retard", h, 6);
    wait_frame_start();
    skip_pulses(249);
    measure_pulse(h, l);
    check(h == 6, "R7 second frame keeps retard", h, 6);
    wait_frame_start();
    skip_pulses(249);
    measure_pulse(h, l);
    check(h == 5, "R7 ignored request not queued", h, 5);
  endtask

  task automatic t_cancel();
    int h, l;
    wait_frame_start();
    fire_req(1'b1);
    rate_sel = 2'd2;
    wait_frame_start();
    measure_pulse(h, l);
    check(h == 4, "R8 new rate at boundary", h, 4);
    skip_pulses(248);
    measure_pulse(h, l);
    check(h == 4, "R9 cancelled frame one", h, 4);
    wait_frame_start();
    skip_pulses(249);
    measure_pulse(h, l);
    check(h == 4, "R9 cancelled frame two", h, 4);
  endtask

  task automatic t_ts(input logic [2:0] mask);
    int h, l, errs, exp;
    ch_en = mask;
    wait_frame_start();
    errs = 0;
    for (int i = 0; i < 20; i++) begin
      exp = ((mask[0] && i < 8) || (mask[1] && i >= 8 && i < 16) ||
             (mask[2] && i >= 16 && i < 18)) ? 1 : 0;
      if (int'(ts_en) != exp) begin
        errs++;
        $display("FAIL R10 pulse %0d actual=%0d expected=%0d", i, ts_en, exp);
      end
      @(negedge clk);
      if (int'(ts_en) != exp) errs++;
      measure_pulse(h, l);
    end
    check(errs == 0, "R10 timeslot enable", errs, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_rate(2'd0, 20, 64, 5);
    t_rate(2'd2, 4, 320, 20);
    t_rate(2'd3, 5, 256, 4);
    t_adjust(2'd1, 5, 249, 1'b1);
    t_ignore();
    t_cancel();
    t_adjust(2'd0, 20, 59, 1'b0);
    t_ts(3'b101);
    t_ts(3'b010);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule